// File: doc/BRIEF.md
# PLA Self-Test Sequence Generator

This block generates the complete test stimulus for a programmable logic array that has been made testable. The array's product lines are split into blocks of `BLK_H` lines. A shift register with one select bit per block sits beside the array, and a small decoder-with-parity array is appended to every block. The generator drives three things: the serial data and shift enable of that select register, the original array inputs, and the extra code inputs. It also marks each cycle whose pattern a response checker should compare, and tags it with a phase code.

A run starts with a walking one through the select register. Next comes a sweep with every block deselected, during which every array output must read zero. Last, each block in turn is selected alone and receives, for each of its product lines, the stored main pattern followed by one auxiliary pattern per bit of the pattern word. Each auxiliary pattern complements exactly one bit of the main pattern. Only one main input vector per product line is stored, in the parameter `MAIN_TBL`. All other patterns are derived from it.

Top module: `pla_tst_gen`

## Requirements
- R1: While reset is high, and after it until a run is started, `busy`, `done`, `pat_valid`, `sr_shift` and `sr_in` are all 0.
- R2: A `start` seen at a clock edge while the block is idle (`busy` low) raises `busy` and shows the first pattern cycle after the second rising edge counted from that edge.
- R3: Phase 0 lasts 2K+1 cycles, where K = ceil(N_PROD/BLK_H). In every one of these cycles `pat_valid`=1, `phase`=0, `sr_shift`=1, and `pat_x`/`pat_ext` are zero. `sr_in` is 1 only in cycle K (counting from 0), so the one reaches the last stage, which is the observed serial output, exactly once, and the register ends all zero.
- R4: Phase 1 gives N_PROD valid cycles with `phase`=1 and `sr_shift`=0, one per product line j in ascending order. Each carries the main pattern of line j with local index j mod BLK_H, and the select register stays all zero.
- R5: The main pattern word is {`pat_ext`, `pat_x`}, with `pat_x` bit 0 as word bit 0. `pat_x` is row j of `MAIN_TBL` (bits j*N_IN upward). `pat_ext` holds the local index in binary in its low clog2(BLK_H) bits, and the XOR of those bits in its top bit.
- R6: Before block b (counting from 0) is tested, there are K cycles with `sr_shift`=1 and `pat_valid`=0. `sr_in` is 1 only in load cycle K-1-b, which leaves only select stage b+1 set (stage 1 takes the serial input and stage K is the serial output).
- R7: In phase 2 (`phase`=2, `sr_shift`=0), block b covers lines b*BLK_H up to the smaller of N_PROD-1 and (b+1)*BLK_H-1, so the last block may be shorter. Each line gives its main word followed by W auxiliary words, where W = clog2(BLK_H)+1+N_IN. Auxiliary word f (1..W) has word bit f-1 complemented.
- R8: A full run asserts `pat_valid` with nonzero phase N_PROD*(3+N_IN+clog2(BLK_H)) times, and a full block gives BLK_H*(2+N_IN+clog2(BLK_H)) phase-2 patterns.
- R9: `done` is high for exactly one cycle, the cycle after the last auxiliary pattern, with `pat_valid`=0 and `busy`=1. `busy` is 0 in the next cycle.
- R10: `start` has no effect while `busy` is high, including the cycle in which `done` is shown. The pattern stream is unchanged and no second run follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pat_valid | output | 1 | The current cycle carries a pattern to be checked |
| phase | output | 2 | 0 register walk, 1 zero sweep, 2 block test |
| sr_shift | output | 1 | Shift enable of the block select register |
| sr_in | output | 1 | Serial data into select stage 1 |
| pat_x | output | N_IN | Original array inputs |
| pat_ext | output | clog2(BLK_H)+1 | Decoder-parity code inputs |

## Verification
The bench builds the block with six product lines, four original inputs and blocks of four lines. This gives two blocks, the second holding only two lines, and a three-bit code with a seven-bit pattern word. With these values the local index wraps during the zero sweep, the short last block ends the run, and two different select loads are reached. Random `start` pulses during every busy cycle, and a directed pulse on the `done` cycle, exercise the ignore rule. A shadow model of the select register confirms where the walking one and each select bit land.

// File: rtl/pla_tst_pkg.sv
package pla_tst_pkg;
  typedef enum logic [1:0] {
    PH_SR    = 2'd0,
    PH_SWEEP = 2'd1,
    PH_BLOCK = 2'd2
  } phase_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SRT,
    S_SWEEP,
    S_LOAD,
    S_BLK,
    S_DONE
  } st_t;
endpackage

// File: rtl/pla_tst_code.sv
// Decoder-parity code of a local product-line index: binary index plus XOR bit on top.
module pla_tst_code #(
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] loc,
  output logic [IDX_W:0]   ext
);
  assign ext = {^loc, loc};
endmodule

// File: rtl/pla_tst_rom.sv
// Main input vector table, one row per product line.
module pla_tst_rom #(
  parameter int N_PROD = 6,
  parameter int N_IN   = 4,
  parameter int LINE_W = 3,
  parameter logic [N_PROD*N_IN-1:0] TBL = '0
) (
  input  logic [LINE_W-1:0] line,
  output logic [N_IN-1:0]   x
);
  always_comb begin
    x = '0;
    for (int j = 0; j < N_PROD; j++) begin
      if (line == LINE_W'(j)) x = TBL[j*N_IN +: N_IN];
    end
  end
endmodule

// File: rtl/pla_tst_seq.sv
// Phase sequencer: walks register test, zero sweep, then load + block test per block.
module pla_tst_seq
  import pla_tst_pkg::*;
#(
  parameter int N_PROD = 6,
  parameter int BLK_H  = 4,
  parameter int WORD_W = 7,
  parameter int LINE_W = 3,
  parameter int IDX_W  = 2,
  parameter int FLIP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              busy_q,
  output logic              c_busy,
  output logic              c_done,
  output logic              c_valid,
  output logic              c_shift,
  output logic              c_sin,
  output logic              c_zero,
  output phase_t            c_phase,
  output logic [LINE_W-1:0] c_line,
  output logic [IDX_W-1:0]  c_loc,
  output logic [FLIP_W-1:0] c_flip
);
  localparam int NBLK  = (N_PROD + BLK_H - 1) / BLK_H;
  localparam int CNT_W = $clog2(2*NBLK + 2);
  localparam int BLK_W = $clog2(NBLK + 1);
  localparam logic [CNT_W-1:0]  CNT_MID   = CNT_W'(NBLK);
  localparam logic [CNT_W-1:0]  CNT_SR_E  = CNT_W'(2*NBLK);
  localparam logic [CNT_W-1:0]  CNT_LD_E  = CNT_W'(NBLK - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(N_PROD - 1);
  localparam logic [IDX_W-1:0]  LOC_LAST  = IDX_W'(BLK_H - 1);
  localparam logic [FLIP_W-1:0] FLIP_LAST = FLIP_W'(WORD_W);

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [BLK_W-1:0]  blk;
  logic [LINE_W-1:0] line;
  logic [IDX_W-1:0]  loc;
  logic [FLIP_W-1:0] flip;

  always_comb begin
    c_busy  = 1'b0;
    c_done  = 1'b0;
    c_valid = 1'b0;
    c_shift = 1'b0;
    c_sin   = 1'b0;
    c_zero  = 1'b0;
    c_phase = PH_BLOCK;
    case (st)
      S_SRT: begin
        c_busy = 1'b1; c_valid = 1'b1; c_shift = 1'b1; c_zero = 1'b1;
        c_sin = (cnt == CNT_MID);
        c_phase = PH_SR;
      end
      S_SWEEP: begin
        c_busy = 1'b1; c_valid = 1'b1; c_phase = PH_SWEEP;
      end
      S_LOAD: begin
        c_busy = 1'b1; c_shift = 1'b1; c_zero = 1'b1;
        c_sin = (cnt == (CNT_LD_E - CNT_W'(blk)));
      end
      S_BLK:  begin c_busy = 1'b1; c_valid = 1'b1; end
      S_DONE: begin c_busy = 1'b1; c_done = 1'b1; end
      default: ;
    endcase
  end

  assign c_line = line;
  assign c_loc  = loc;
  assign c_flip = flip;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; blk <= '0; line <= '0; loc <= '0; flip <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && !busy_q) begin st <= S_SRT; cnt <= '0; end
        S_SRT: begin
          if (cnt == CNT_SR_E) begin
            st <= S_SWEEP; line <= '0; loc <= '0; flip <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_SWEEP: begin
          if (line == LINE_LAST) begin
            st <= S_LOAD; cnt <= '0; blk <= '0; line <= '0; loc <= '0;
          end else begin
            line <= line + 1'b1;
            loc  <= (loc == LOC_LAST) ? '0 : loc + 1'b1;
          end
        end
        S_LOAD: begin
          if (cnt == CNT_LD_E) begin
            st <= S_BLK; flip <= '0; loc <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_BLK: begin
          if (flip != FLIP_LAST) flip <= flip + 1'b1;
          else begin
            flip <= '0;
            if (line == LINE_LAST) st <= S_DONE;
            else begin
              line <= line + 1'b1;
              if (loc == LOC_LAST) begin
                st <= S_LOAD; cnt <= '0; blk <= blk + 1'b1; loc <= '0;
              end else loc <= loc + 1'b1;
            end
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pla_tst_gen.sv
// Top: sequencer, table, code builder, bit-flip mask and registered outputs.
module pla_tst_gen
  import pla_tst_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_PROD = 6,
  parameter int BLK_H  = 4,
  parameter logic [N_PROD*N_IN-1:0] MAIN_TBL = 24'h69C5A3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic                     pat_valid,
  output logic [1:0]               phase,
  output logic                     sr_shift,
  output logic                     sr_in,
  output logic [N_IN-1:0]          pat_x,
  output logic [$clog2(BLK_H):0]   pat_ext
);
  localparam int IDX_W  = $clog2(BLK_H);
  localparam int CODE_W = IDX_W + 1;
  localparam int WORD_W = CODE_W + N_IN;
  localparam int LINE_W = $clog2(N_PROD + 1);
  localparam int FLIP_W = $clog2(WORD_W + 2);

  logic c_busy, c_done, c_valid, c_shift, c_sin, c_zero;
  phase_t c_phase;
  logic [LINE_W-1:0] c_line;
  logic [IDX_W-1:0]  c_loc;
  logic [FLIP_W-1:0] c_flip;
  logic [N_IN-1:0]   x_c;
  logic [CODE_W-1:0] ext_c;
  logic [WORD_W-1:0] flip_mask, word;

  pla_tst_seq #(
    .N_PROD(N_PROD), .BLK_H(BLK_H), .WORD_W(WORD_W),
    .LINE_W(LINE_W), .IDX_W(IDX_W), .FLIP_W(FLIP_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy_q(busy),
    .c_busy(c_busy), .c_done(c_done), .c_valid(c_valid), .c_shift(c_shift),
    .c_sin(c_sin), .c_zero(c_zero), .c_phase(c_phase), .c_line(c_line),
    .c_loc(c_loc), .c_flip(c_flip)
  );

  pla_tst_rom #(
    .N_PROD(N_PROD), .N_IN(N_IN), .LINE_W(LINE_W), .TBL(MAIN_TBL)
  ) u_rom (.line(c_line), .x(x_c));

  pla_tst_code #(.IDX_W(IDX_W)) u_code (.loc(c_loc), .ext(ext_c));

  for (genvar b = 0; b < WORD_W; b++) begin : g_mask
    assign flip_mask[b] = (c_flip == FLIP_W'(b + 1));
  end

  assign word = c_zero ? '0 : ({ext_c, x_c} ^ flip_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; pat_valid <= 1'b0; phase <= 2'd0;
      sr_shift <= 1'b0; sr_in <= 1'b0; pat_x <= '0; pat_ext <= '0;
    end else begin
      busy      <= c_busy;
      done      <= c_done;
      pat_valid <= c_valid;
      phase     <= c_phase;
      sr_shift  <= c_shift;
      sr_in     <= c_sin;
      pat_x     <= word[N_IN-1:0];
      pat_ext   <= word[WORD_W-1:N_IN];
    end
  end
endmodule

// File: rtl/pla_tst_chk.sv
module pla_tst_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       pat_valid,
  input logic [1:0] phase,
  input logic       sr_shift,
  input logic       sr_in
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!pat_valid && !sr_shift && !sr_in)); // R1
  AST_START_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start, 2)); // R2
  AST_WALK_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    (pat_valid && phase == 2'd0) |-> sr_shift); // R3
  AST_SWEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pat_valid && phase == 2'd1) |-> (!sr_shift && !sr_in)); // R4
  AST_LOAD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (busy && sr_shift && phase == 2'd2) |-> !pat_valid); // R6
  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pat_valid && phase == 2'd2) |-> !sr_shift); // R7
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    pat_valid |-> (phase != 2'd3)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy)); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy && !pat_valid)); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R10
endmodule

bind pla_tst_gen pla_tst_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .pat_valid(pat_valid), .phase(phase), .sr_shift(sr_shift), .sr_in(sr_in)
);

// File: tb/pla_tst_gen_bench.sv
module pla_tst_gen_bench;
  localparam int NI = 4;
  localparam int NP = 6;
  localparam int BH = 4;
  localparam logic [NP*NI-1:0] TBL = 24'h69C5A3;
  localparam int NB = (NP + BH - 1) / BH;
  localparam int LG = $clog2(BH);
  localparam int WW = LG + 1 + NI;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic busy, done, pat_valid, sr_shift, sr_in;
  logic [1:0] phase;
  logic [NI-1:0] pat_x;
  logic [LG:0] pat_ext;

  int total = 0, bad = 0, nvalid = 0, nblk0 = 0;
  bit finished = 1'b0;
  logic [NB:1] sr_mdl = '0;

  always #5 clk = ~clk;

  pla_tst_gen #(.N_IN(NI), .N_PROD(NP), .BLK_H(BH), .MAIN_TBL(TBL)) u_pla_tst_gen (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .pat_valid(pat_valid), .phase(phase), .sr_shift(sr_shift), .sr_in(sr_in),
    .pat_x(pat_x), .pat_ext(pat_ext)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_x(int j);
    return int'((TBL >> (j*NI)) & {{(NP*NI-NI){1'b0}}, {NI{1'b1}}});
  endfunction

  function automatic int f_code(int loc);
    int p = 0;
    for (int i = 0; i < LG; i++) p ^= (loc >> i) & 1;
    return loc | (p << LG);
  endfunction

  function automatic int f_word(int j, int loc);
    return f_x(j) | (f_code(loc) << NI);
  endfunction

  // Compare one cycle at the current negedge, update the select model, then advance.
  task automatic obs(string tag, int ev, int eph, int esh, int esin, int ew);
    chk({tag, " busy"}, int'(busy), 1);
    chk({tag, " done"}, int'(done), 0);
    chk({tag, " valid"}, int'(pat_valid), ev);
    chk({tag, " shift"}, int'(sr_shift), esh);
    chk({tag, " sr_in"}, int'(sr_in), esin);
    if (eph >= 0) chk({tag, " phase"}, int'(phase), eph);
    if (ew >= 0) chk({tag, " word"}, int'({pat_ext, pat_x}), ew);
    if (sr_shift) sr_mdl = {sr_mdl[NB-1:1], sr_in};
    if (pat_valid && phase != 2'd0) nvalid++;
    start = ($urandom_range(0, 1) == 1);
    @(negedge clk);
  endtask

  task automatic run(int gap);
    int rk_ones = 0;
    nvalid = 0;
    nblk0 = 0;
    repeat (gap) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy before second edge", int'(busy), 0);
    @(negedge clk);
    for (int c = 0; c <= 2*NB; c++) begin
      obs("R3", 1, 0, 1, (c == NB) ? 1 : 0, 0);
      if (sr_mdl[NB]) rk_ones++;
    end
    chk("R3 one seen at serial output", rk_ones, 1);
    chk("R3 register cleared", int'(sr_mdl), 0);
    for (int j = 0; j < NP; j++) begin
      obs("R4 R5 sweep", 1, 1, 0, 0, f_word(j, j % BH));
      chk("R4 select all zero", int'(sr_mdl), 0);
    end
    for (int b = 0; b < NB; b++) begin
      int last = ((b+1)*BH < NP) ? (b+1)*BH - 1 : NP - 1;
      for (int c = 0; c < NB; c++)
        obs("R6 load", 0, -1, 1, (c == NB-1-b) ? 1 : 0, -1);
      chk("R6 single select", int'(sr_mdl), 1 << b);
      for (int j = b*BH; j <= last; j++) begin
        for (int f = 0; f <= WW; f++) begin
          int w = f_word(j, j - b*BH) ^ ((f == 0) ? 0 : (1 << (f-1)));
          obs("R5 R7 block", 1, 2, 0, 0, w);
          if (b == 0) nblk0++;
        end
      end
    end
    chk("R8 total pattern count", nvalid, NP*(3 + NI + LG));
    chk("R8 full block count", nblk0, BH*(2 + NI + LG));
    chk("R9 done pulse", int'(done), 1);
    chk("R9 no valid on done", int'(pat_valid), 0);
    chk("R9 busy on done", int'(busy), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done dropped", int'(done), 0);
    chk("R9 busy dropped", int'(busy), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 start on done ignored valid", int'(pat_valid), 0);
      chk("R10 start on done ignored busy", int'(busy), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset valid", int'(pat_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle busy", int'(busy), 0);
    chk("R1 idle done", int'(done), 0);
    chk("R1 idle valid", int'(pat_valid), 0);
    chk("R1 idle shift", int'(sr_shift), 0);
    chk("R1 idle sr_in", int'(sr_in), 0);
    run(2);
    run($urandom_range(0, 5));
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R9 actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule